// File: doc/BRIEF.md
# Link BIST Error Monitor

This block is the receive-side checker for an at-speed self test of a serial video link. While the test-enable input is high, it asks the far-end transmitter to send a test pattern by raising a request flag. It then compares every received frame word against a reference sequence that it generates itself. The length of the enable pulse sets how long the test runs.

The pass output reports errors in two ways. While the test runs, each errored frame shows up as a low pulse one half pixel-clock period long. After the enable drops, the output holds the verdict of the test that just ended. A 16-bit saturating counter records how many frames were in error, and it can be read once the test is over. A clock-source select input is registered and passed through so that the clocking logic outside the block can choose between the external pixel clock and an internal oscillator.

Frames are checked only while the link lock input is high. The first accepted frames are not compared, which gives the transmitter time to align its pattern.

Top module: `lbist_err_mon`

## Requirements
- R1: `pattern_req` equals `test_en` delayed by one clock, and `clk_sel_o` equals `clk_src_sel` delayed by one clock.
- R2: A test starts on the first clock edge that samples `test_en` high after it was low. At that edge the reference state is set to 7'h7F, `err_cnt` is cleared to 0, the verdict is set to pass, and any frame offered in that cycle is discarded.
- R3: The reference sequence uses a 7-bit state `s`. One step computes `n = s[6]^s[5]` and `s = {s[5:0], n}`. A word is W successive values of `n`, with the first one placed in the MSB. The state advances by one word per accepted frame.
- R4: A frame is accepted only at an edge where `test_en` is high and is not the start edge, and where `rx_valid` and `link_lock` are also high. Any other frame neither advances the reference nor can cause an error.
- R5: The first two accepted frames of a test are never compared, so they can neither pulse `pass_out` nor count.
- R6: If a compared frame differs from its reference word, `pass_out` is high in the first (clock-high) half of the next clock cycle and low in its second (clock-low) half. At all other times while the test runs, `pass_out` is high.
- R7: From the clock cycle after `test_en` is sampled low, `pass_out` is steady. It is high if the test saw no mismatched frame and low otherwise, and it holds until the next test start or reset.
- R8: `err_cnt` counts mismatched frames of the current test and saturates at 16'hFFFF.
- R9: Synchronous active-high `rst` drives `pass_out` high, `err_cnt` to 0 and `pattern_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel (test) clock |
| rst | input | 1 | Synchronous active-high reset / power-down |
| test_en | input | 1 | Test enable; its pulse width sets the test duration |
| clk_src_sel | input | 1 | Test clock source choice: 0 external pixel clock, 1 internal oscillator |
| link_lock | input | 1 | Link lock indication |
| rx_valid | input | 1 | Frame-valid strobe |
| rx_word | input | 8 | Received frame word |
| pattern_req | output | 1 | Request for the far end to send the test pattern |
| clk_sel_o | output | 1 | Registered clock-source choice |
| pass_out | output | 1 | Real-time error pulses during the test; held verdict afterwards |
| err_cnt | output | 16 | Saturating count of errored frames |

## Verification
The bench moves a single corrupted frame across every position of a ten-frame test. A design that compares the alignment frames would pulse and fail on positions 0 and 1, and a design that skips too many frames would miss position 2. Each pulse is sampled in both halves of the clock cycle, so a pulse that lasts a full cycle, or one that lands in the wrong cycle, is caught. The bench also interleaves unlocked frames and idle gaps, which shows up any reference that advances on a frame it should ignore. Further runs check that the held verdict survives idle traffic, that a new start or a reset clears it, and that the counter stops at 16'hFFFF instead of wrapping.

// File: rtl/lbist_pkg.sv
package lbist_pkg;
  localparam logic [6:0] PRBS_SEED = 7'h7F;

  typedef enum logic [1:0] {
    CHK_IDLE  = 2'd0,
    CHK_ALIGN = 2'd1,
    CHK_LIVE  = 2'd2
  } chk_state_e;

  function automatic logic [6:0] prbs7_step(input logic [6:0] s);
    return {s[5:0], s[6] ^ s[5]};
  endfunction
endpackage

// File: rtl/lbist_prbs_gen.sv
module lbist_prbs_gen #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         seed_load,
  input  logic         advance,
  output logic [W-1:0] ref_word
);
  import lbist_pkg::*;

  logic [6:0]   st_q;
  logic [6:0]   st_nxt;
  logic [6:0]   walk;
  logic [W-1:0] word;

  // Unroll W single-bit steps to form one word and the following state
  always_comb begin
    walk = st_q;
    word = '0;
    for (int i = 0; i < W; i++) begin
      walk = prbs7_step(walk);
      word = {word[W-2:0], walk[0]};
    end
    st_nxt = walk;
  end

  always_ff @(posedge clk) begin
    if (rst || seed_load) st_q <= PRBS_SEED;
    else if (advance)     st_q <= st_nxt;
  end

  assign ref_word = word;
endmodule

// File: rtl/lbist_frame_chk.sv
module lbist_frame_chk #(
  parameter int W    = 8,
  parameter int SKIP = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         active,
  input  logic         frm_valid,
  input  logic         lock,
  input  logic [W-1:0] rx_word,
  input  logic [W-1:0] ref_word,
  output logic         advance,
  output logic         err_pulse
);
  import lbist_pkg::*;

  localparam int SKW = $clog2(SKIP + 2);
  localparam logic [SKW-1:0] SKIP_LD = SKW'(SKIP);

  chk_state_e     state_q;
  logic [SKW-1:0] skip_q;
  logic           accept;
  logic           mismatch;

  assign accept   = active && frm_valid && lock;
  assign advance  = accept;
  assign mismatch = accept && (state_q == CHK_LIVE) && (rx_word != ref_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CHK_IDLE;
      skip_q  <= '0;
    end else if (start) begin
      state_q <= (SKIP == 0) ? CHK_LIVE : CHK_ALIGN;
      skip_q  <= SKIP_LD;
    end else if (!active) begin
      state_q <= CHK_IDLE;
    end else if (accept && state_q == CHK_ALIGN) begin
      skip_q <= skip_q - 1'b1;
      if (skip_q == SKW'(1)) state_q <= CHK_LIVE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err_pulse <= 1'b0;
    else     err_pulse <= mismatch;
  end
endmodule

// File: rtl/lbist_verdict.sv
module lbist_verdict #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             running,
  input  logic             err_pulse,
  output logic             pass_out,
  output logic [CNT_W-1:0] err_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic verdict_q;
  logic level;

  always_ff @(posedge clk) begin
    if (rst || start)   verdict_q <= 1'b1;
    else if (err_pulse) verdict_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || start) err_cnt <= '0;
    else if (err_pulse && err_cnt != CNT_MAX) err_cnt <= err_cnt + 1'b1;
  end

  // Level: high while running, held verdict otherwise.
  assign level = running ? 1'b1 : verdict_q;
  // Error flag gated by the low phase of the clock gives a half-period pulse.
  assign pass_out = level & ~(err_pulse & ~clk);
endmodule

// File: rtl/lbist_err_mon.sv
module lbist_err_mon #(
  parameter int W     = 8,
  parameter int SKIP  = 2,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             test_en,
  input  logic             clk_src_sel,
  input  logic             link_lock,
  input  logic             rx_valid,
  input  logic [W-1:0]     rx_word,
  output logic             pattern_req,
  output logic             clk_sel_o,
  output logic             pass_out,
  output logic [CNT_W-1:0] err_cnt
);
  logic         run_q;
  logic         start;
  logic         active;
  logic         advance;
  logic         err_pulse;
  logic [W-1:0] ref_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      clk_sel_o <= 1'b0;
    end else begin
      run_q     <= test_en;
      clk_sel_o <= clk_src_sel;
    end
  end

  assign start       = test_en & ~run_q;
  assign active      = test_en & run_q;
  assign pattern_req = run_q;

  lbist_prbs_gen #(.W(W)) prbs_i (
    .clk       (clk),
    .rst       (rst),
    .seed_load (start),
    .advance   (advance),
    .ref_word  (ref_word)
  );

  lbist_frame_chk #(.W(W), .SKIP(SKIP)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .active    (active),
    .frm_valid (rx_valid),
    .lock      (link_lock),
    .rx_word   (rx_word),
    .ref_word  (ref_word),
    .advance   (advance),
    .err_pulse (err_pulse)
  );

  lbist_verdict #(.CNT_W(CNT_W)) vrd_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .running   (run_q),
    .err_pulse (err_pulse),
    .pass_out  (pass_out),
    .err_cnt   (err_cnt)
  );
endmodule

// File: rtl/lbist_err_mon_chk.sv
module lbist_err_mon_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             test_en,
  input logic             link_lock,
  input logic             rx_valid,
  input logic             pattern_req,
  input logic             err_pulse,
  input logic [CNT_W-1:0] err_cnt
);
  logic past_ok = 1'b0;
  logic start_w;

  always_ff @(posedge clk) past_ok <= !rst;

  assign start_w = test_en && !pattern_req;

  AST_REQ_TRACK: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> pattern_req == $past(test_en)); // R1

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (past_ok && start_w) |=> err_cnt == '0); // R2

  AST_NO_CHECK_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    (past_ok && rx_valid && !link_lock) |=> !err_pulse); // R4

  AST_NO_CHECK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !test_en) |=> !err_pulse); // R4

  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    (past_ok && err_cnt == {CNT_W{1'b1}} && !start_w) |=> err_cnt == {CNT_W{1'b1}}); // R8

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !start_w) |=> (err_cnt - $past(err_cnt)) <= CNT_W'(1)); // R8
endmodule

bind lbist_err_mon lbist_err_mon_chk #(.CNT_W(CNT_W)) mon_chk_i (
  .clk         (clk),
  .rst         (rst),
  .test_en     (test_en),
  .link_lock   (link_lock),
  .rx_valid    (rx_valid),
  .pattern_req (pattern_req),
  .err_pulse   (err_pulse),
  .err_cnt     (err_cnt)
);

// File: tb/lbist_err_mon_tb_top.sv
`timescale 1ns/1ps
module lbist_err_mon_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        test_en = 1'b0;
  logic        clk_src_sel = 1'b0;
  logic        link_lock = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_word = 8'h00;
  logic        pattern_req;
  logic        clk_sel_o;
  logic        pass_out;
  logic [15:0] err_cnt;

  int total = 0;
  int bad = 0;

  logic [6:0] m_st;
  int         m_idx;
  int         m_errs;

  always #4 clk = ~clk;

  lbist_err_mon dut_i (
    .clk(clk), .rst(rst), .test_en(test_en), .clk_src_sel(clk_src_sel),
    .link_lock(link_lock), .rx_valid(rx_valid), .rx_word(rx_word),
    .pattern_req(pattern_req), .clk_sel_o(clk_sel_o),
    .pass_out(pass_out), .err_cnt(err_cnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Inputs change at edge+6 ns (clock low)
  task automatic step();
    @(posedge clk);
    #6;
  endtask

  task automatic next_ref(output logic [7:0] w);
    w = 8'h00;
    for (int b = 0; b < 8; b++) begin
      m_st = {m_st[5:0], m_st[6] ^ m_st[5]};
      w = {w[6:0], m_st[0]};
    end
  endtask

  task automatic start_test();
    test_en = 1'b1;
    rx_valid = 1'b1;          // offered on the start edge: must be discarded (R2)
    rx_word = 8'h3C;
    step();
    rx_valid = 1'b0;
    m_st = 7'h7F; m_idx = 0; m_errs = 0;
    chk("R2 cnt cleared", 32'(err_cnt), 32'd0);
    chk("R2 pass high at start", 32'(pass_out), 32'd1);
  endtask

  task automatic send(input logic vld, input logic lck, input logic corrupt);
    logic [7:0] w;
    logic       acc;
    logic       exp_err;
    acc = vld && lck;
    exp_err = 1'b0;
    if (acc) begin
      next_ref(w);
      if (corrupt) w = w ^ 8'h01;
      exp_err = corrupt && (m_idx >= 2);
      m_idx++;
      if (exp_err) m_errs++;
    end else begin
      w = 8'hA5;
    end
    rx_valid = vld; link_lock = lck; rx_word = w;
    @(posedge clk);
    #2;
    chk("R6 high in first half", 32'(pass_out), 32'd1);
    #4;
    chk(exp_err ? "R6 low pulse" : "R5 no pulse", 32'(pass_out), 32'(!exp_err));
    rx_valid = 1'b0; link_lock = 1'b1;
  endtask

  task automatic end_test();
    test_en = 1'b0;
    step();
    step();
    chk("R7 held verdict", 32'(pass_out), 32'(m_errs == 0));
    chk("R8 err count", 32'(err_cnt), 32'(m_errs > 65535 ? 65535 : m_errs));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(); step();
    rst = 1'b0;
    step();
    // R9 reset state
    chk("R9 pass after reset", 32'(pass_out), 32'd1);
    chk("R9 cnt after reset", 32'(err_cnt), 32'd0);
    chk("R9 req after reset", 32'(pattern_req), 32'd0);

    // R1 request and clock select tracking
    clk_src_sel = 1'b1;
    step();
    chk("R1 clk_sel high", 32'(clk_sel_o), 32'd1);
    clk_src_sel = 1'b0;
    step();
    chk("R1 clk_sel low", 32'(clk_sel_o), 32'd0);
    test_en = 1'b1;
    chk("R1 req before edge", 32'(pattern_req), 32'd0);
    step();
    chk("R1 req follows enable", 32'(pattern_req), 32'd1);
    test_en = 1'b0;
    step();
    chk("R1 req drops", 32'(pattern_req), 32'd0);
    step();

    // R3 clean test: correct pattern gives no error
    start_test();
    for (int i = 0; i < 20; i++) send(1'b1, 1'b1, 1'b0);
    end_test();
    chk("R3 clean verdict", 32'(pass_out), 32'd1);

    // R5/R6 sweep a single bad frame across positions, with idle gaps
    for (int j = 0; j < 10; j++) begin
      start_test();
      for (int i = 0; i < 10; i++) begin
        if (i == 4) send(1'b0, 1'b1, 1'b0);
        send(1'b1, 1'b1, i == j);
      end
      end_test();
    end

    // R4 unlocked frames ignored and do not advance the reference
    start_test();
    for (int i = 0; i < 12; i++) begin
      send(1'b1, 1'b0, 1'b1);
      send(1'b1, 1'b1, 1'b0);
    end
    end_test();
    chk("R4 unlocked ignored", 32'(pass_out), 32'd1);

    // R7 held fail survives idle traffic, then a new start clears it
    start_test();
    for (int i = 0; i < 6; i++) send(1'b1, 1'b1, i == 3 || i == 5);
    end_test();
    for (int i = 0; i < 10; i++) begin
      rx_valid = 1'b1; rx_word = 8'(i);
      @(posedge clk);
      #2;
      chk("R7 hold high phase", 32'(pass_out), 32'd0);
      #4;
      chk("R7 hold low phase", 32'(pass_out), 32'd0);
    end
    rx_valid = 1'b0;
    chk("R7 count held", 32'(err_cnt), 32'd2);
    start_test();
    chk("R2 restart clears fail", 32'(pass_out), 32'd1);
    for (int i = 0; i < 4; i++) send(1'b1, 1'b1, 1'b0);
    end_test();

    // R9 reset clears a held fail
    start_test();
    for (int i = 0; i < 4; i++) send(1'b1, 1'b1, 1'b1);
    end_test();
    rst = 1'b1;
    step();
    rst = 1'b0;
    step();
    chk("R9 reset clears verdict", 32'(pass_out), 32'd1);
    chk("R9 reset clears count", 32'(err_cnt), 32'd0);

    // R8 saturation
    start_test();
    for (int i = 0; i < 65540; i++) begin
      logic [7:0] w;
      next_ref(w);
      if (m_idx >= 2) m_errs++;
      m_idx++;
      rx_valid = 1'b1; rx_word = w ^ 8'h80;
      step();
    end
    rx_valid = 1'b0;
    end_test();
    chk("R8 saturated", 32'(err_cnt), 32'hFFFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule